// File: doc/BRIEF.md
# Command-Byte Serial Register Port

This block is the host-facing register port of a converter-style device. An external controller talks to it over four pins: an active-low select, a serial clock, a data input and a data output. Each exchange opens with an 8-bit command byte, which names one register and a direction. A 24-bit data word follows, MSB first, either into the named register or out of it. The port holds one offset register and one gain register per channel, and one configuration register. All of them are also presented in parallel to the conversion logic. The serial pins are brought into the system clock domain through a small synchronizer. Serial clock edges are then handled as single-cycle strobes, so the serial clock must run well below the system clock.

After a data word the port goes back to waiting for a command byte with no outside help. Because of that, the select pin may be tied low for good and the port runs on command framing alone. Raising select ends any exchange in progress. A write reaches its register only when the 24th data bit arrives.

The controller has four states. WAIT_SEL (ST_IDLE) is held while select is high. CMD_SHIFT (ST_CMD) collects the command byte. DATA_IN (ST_WR) collects a write word, and DATA_OUT (ST_RD) shifts a read word out. The transitions are:
- ST_IDLE→ST_CMD when select falls.
- ST_CMD→ST_WR on a valid write byte, and ST_CMD→ST_RD on a valid read byte.
- ST_CMD→ST_CMD on an invalid byte.
- ST_WR→ST_CMD and ST_RD→ST_CMD after the 24th data bit.
- Any state→ST_IDLE whenever select is high.

Top module: `cmd_serial_port`

## Requirements
- R1: Serial clock edges that arrive while select is high have no effect: no register changes and no bits are counted.
- R2: `sdo_oe` is low whenever `sel_n` is high and high whenever `sel_n` is low, so the data pad is released while the port is deselected.
- R3: With `sel_n` held low for the whole run, back-to-back transactions work using command framing alone.
- R4: A transaction is 8 command bits followed by 24 data bits, all MSB first. `sdi` is taken on the rising serial clock edge, and `sdo` changes on the falling edge.
- R5: The command byte is laid out as follows. Bit 7 must be 0. Bits 6:4 hold the channel index, counted from 0. Bit 3 is 1 for a read and 0 for a write. Bits 2:0 pick the register: 1 is offset, 2 is gain, 3 is configuration. The configuration register requires channel 0. So 0x02 writes the gain of channel 0, and 0x0A reads it.
- R6: A write places its 24 data bits in the selected register only, after the 24th bit, and the new value shows on that register's parallel output.
- R7: A read shifts out the selected register's current value on `sdo`, MSB first. Each bit is valid before the rising edge that ends it.
- R8: After a 24-bit data phase the port returns to command mode by itself.
- R9: Raising `sel_n` during a transfer aborts it. No register changes, and the next transaction starts at bit 0 of a new command.
- R10: A command byte with bit 7 set, an unknown register code, a channel at or above NUM_CH, or configuration with a nonzero channel is ignored. The following 8 bits are then taken as a fresh command.
- R11: After reset every gain register holds 0x800000, while every offset register and the configuration register hold 0.
- R12: `sdo` stays 0 outside the data phase of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select |
| sclk | input | 1 | Serial bit clock, sampled by clk |
| sdi | input | 1 | Serial data into the port |
| sdo | output | 1 | Serial data out of the port |
| sdo_oe | output | 1 | Output enable for the sdo pad |
| cfg_o | output | DATA_W | Configuration register |
| gain_o | output | NUM_CH*DATA_W | Gain registers, channel 0 in the low bits |
| offset_o | output | NUM_CH*DATA_W | Offset registers, channel 0 in the low bits |

## Verification
The assertions take two things for granted about the inputs. First, each serial clock level lasts longer than the synchronizer delay, so every pin edge becomes exactly one rise or fall strobe. Second, `sdi` is settled before the rising edge that samples it. The bench meets both conditions: it holds each serial clock level for six system clocks and changes `sdi` only while the serial clock is low. It also leaves select steady for several clocks around any change, so the abort and deselect cases are seen cleanly.

// File: rtl/srp_pkg.sv
package srp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_WR   = 2'd2,
        ST_RD   = 2'd3
    } srp_state_e;

    typedef enum logic [2:0] {
        RS_NONE   = 3'd0,
        RS_OFFSET = 3'd1,
        RS_GAIN   = 3'd2,
        RS_CFG    = 3'd3
    } srp_reg_e;

    localparam int CMD_W = 8;

    typedef struct packed {
        logic     valid;
        logic     rd;
        logic [2:0] ch;
        srp_reg_e sel;
    } srp_cmd_t;

    function automatic srp_cmd_t srp_decode(input logic [CMD_W-1:0] b, input int num_ch);
        srp_cmd_t c;
        c.rd  = b[3];
        c.ch  = b[6:4];
        c.sel = srp_reg_e'(b[2:0]);
        c.valid = 1'b0;
        if (!b[7]) begin
            if (b[2:0] == 3'd3)
                c.valid = (b[6:4] == 3'd0);
            else if (b[2:0] == 3'd1 || b[2:0] == 3'd2)
                c.valid = (int'(b[6:4]) < num_ch);
        end
        return c;
    endfunction

endpackage

// File: rtl/srp_sync_edge.sv
module srp_sync_edge #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] pipe_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            pipe_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
            prev_q <= pipe_q[STAGES-1];
        end
    end

    assign sync_o = pipe_q[STAGES-1];
    assign rise_o = sync_o & ~prev_q;
    assign fall_o = ~sync_o & prev_q;
endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
    import srp_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 24,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_s,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [2:0]        rd_ch,
    output srp_reg_e          rd_sel,
    output logic              wr_stb,
    output logic [2:0]        wr_ch,
    output srp_reg_e          wr_sel,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output srp_state_e        state_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    srp_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [DATA_W-1:0] rx_q, rx_d, rx_bits;
    srp_cmd_t          cmd_q, cmd_d, dec;
    logic [DATA_W-1:0] tx_q;
    logic              sdo_q;
    logic              load_tx;

    assign rx_bits = {rx_q[DATA_W-2:0], sdi_s};
    assign dec     = srp_decode(rx_bits[CMD_W-1:0], NUM_CH);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rx_d    = rx_q;
        cmd_d   = cmd_q;
        wr_stb  = 1'b0;
        load_tx = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                state_d = ST_CMD;
                cnt_d   = '0;
            end
            ST_CMD: if (sclk_rise) begin
                rx_d = rx_bits;
                if (cnt_q == CMD_LAST) begin
                    cnt_d = '0;
                    if (dec.valid) begin
                        cmd_d   = dec;
                        state_d = dec.rd ? ST_RD : ST_WR;
                        load_tx = dec.rd;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_WR: if (sclk_rise) begin
                rx_d = rx_bits;
                if (cnt_q == DATA_LAST) begin
                    wr_stb  = 1'b1;
                    state_d = ST_CMD;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RD: if (sclk_rise) begin
                if (cnt_q == DATA_LAST) begin
                    state_d = ST_CMD;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (sel_s) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            wr_stb  = 1'b0;
            load_tx = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rx_q    <= '0;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rx_q    <= rx_d;
            cmd_q   <= cmd_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q  <= '0;
            sdo_q <= 1'b0;
        end else begin
            if (load_tx)
                tx_q <= rd_data;
            else if (state_q == ST_RD && sclk_fall)
                tx_q <= {tx_q[DATA_W-2:0], 1'b0};
            if (state_d != ST_RD)
                sdo_q <= 1'b0;
            else if (state_q == ST_RD && sclk_fall)
                sdo_q <= tx_q[DATA_W-1];
        end
    end

    assign rd_ch   = dec.ch;
    assign rd_sel  = dec.sel;
    assign wr_ch   = cmd_q.ch;
    assign wr_sel  = cmd_q.sel;
    assign wr_data = rx_bits;
    assign sdo     = sdo_q;
    assign state_o = state_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/srp_regfile.sv
module srp_regfile
    import srp_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 24,
    parameter logic [DATA_W-1:0] GAIN_RST = {1'b1, {(DATA_W-1){1'b0}}}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_stb,
    input  logic [2:0]               wr_ch,
    input  srp_reg_e                 wr_sel,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [2:0]               rd_ch,
    input  srp_reg_e                 rd_sel,
    output logic [DATA_W-1:0]        rd_data,
    output logic [DATA_W-1:0]        cfg_o,
    output logic [NUM_CH*DATA_W-1:0] gain_o,
    output logic [NUM_CH*DATA_W-1:0] offset_o
);
    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] gain_q [NUM_CH];
    logic [DATA_W-1:0] off_q  [NUM_CH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else if (wr_stb && wr_sel == RS_CFG) cfg_q <= wr_data;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gain_q[c] <= GAIN_RST;
                off_q[c]  <= '0;
            end else if (wr_stb && wr_ch == 3'(c)) begin
                if (wr_sel == RS_GAIN)   gain_q[c] <= wr_data;
                if (wr_sel == RS_OFFSET) off_q[c]  <= wr_data;
            end
        end
        assign gain_o[c*DATA_W +: DATA_W]   = gain_q[c];
        assign offset_o[c*DATA_W +: DATA_W] = off_q[c];
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel == RS_CFG) rd_data = cfg_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_ch == 3'(c)) begin
                if (rd_sel == RS_GAIN)   rd_data = gain_q[c];
                if (rd_sel == RS_OFFSET) rd_data = off_q[c];
            end
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/cmd_serial_port.sv
module cmd_serial_port
    import srp_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int DATA_W      = 24,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(DATA_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel_n,
    input  logic                     sclk,
    input  logic                     sdi,
    output logic                     sdo,
    output logic                     sdo_oe,
    output logic [DATA_W-1:0]        cfg_o,
    output logic [NUM_CH*DATA_W-1:0] gain_o,
    output logic [NUM_CH*DATA_W-1:0] offset_o
);
    logic [2:0] pin_sync, pin_rise, pin_fall;
    logic       sel_s, sclk_rise, sclk_fall, sdi_s;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic [2:0]  rd_ch, wr_ch;
    srp_reg_e    rd_sel, wr_sel;
    logic        wr_stb;
    srp_state_e  state;
    logic [CNT_W-1:0] cnt;

    srp_sync_edge #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_i({sdi, sclk, sel_n}),
        .sync_o(pin_sync), .rise_o(pin_rise), .fall_o(pin_fall)
    );

    assign sel_s     = pin_sync[0];
    assign sclk_rise = pin_rise[1];
    assign sclk_fall = pin_fall[1];
    assign sdi_s     = pin_sync[2];

    srp_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .sdi_s(sdi_s), .rd_data(rd_data),
        .rd_ch(rd_ch), .rd_sel(rd_sel), .wr_stb(wr_stb), .wr_ch(wr_ch),
        .wr_sel(wr_sel), .wr_data(wr_data), .sdo(sdo), .state_o(state), .cnt_o(cnt)
    );

    srp_regfile #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_ch(wr_ch), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
        .cfg_o(cfg_o), .gain_o(gain_o), .offset_o(offset_o)
    );

    assign sdo_oe = ~sel_n;
endmodule

// File: rtl/srp_checker.sv
module srp_checker
    import srp_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 24,
    parameter int CNT_W  = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sel_s,
    input logic                     sclk_rise,
    input logic                     wr_stb,
    input srp_state_e               state,
    input logic [CNT_W-1:0]         cnt,
    input logic                     sdo,
    input logic [DATA_W-1:0]        cfg_o,
    input logic [NUM_CH*DATA_W-1:0] gain_o,
    input logic [NUM_CH*DATA_W-1:0] offset_o
);
    AST_DESEL_HOLDS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> ($stable(gain_o) && $stable(offset_o) && $stable(cfg_o))); // R9
    AST_DESEL_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> (state == ST_IDLE)); // R1
    AST_SDO_LOW_OUTSIDE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RD) |-> !sdo); // R12
    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < DATA_W); // R4
    AST_WRITE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (sclk_rise && !sel_s)); // R6
    AST_CMD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (state == ST_CMD)); // R8
endmodule

bind cmd_serial_port srp_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .sclk_rise(sclk_rise), .wr_stb(wr_stb),
    .state(state), .cnt(cnt), .sdo(sdo), .cfg_o(cfg_o), .gain_o(gain_o), .offset_o(offset_o)
);

// File: tb/cmd_serial_port_tb.sv
module cmd_serial_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 2;
    localparam int DW     = 24;
    localparam int HALF   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_oe;
    logic [DW-1:0] cfg_o;
    logic [NUM_CH*DW-1:0] gain_o, offset_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [DW-1:0] m_gain [NUM_CH];
    logic [DW-1:0] m_off  [NUM_CH];
    logic [DW-1:0] m_cfg;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_serial_port #(.NUM_CH(NUM_CH), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .cfg_o(cfg_o), .gain_o(gain_o), .offset_o(offset_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R5 encoding, written from the requirement
    function automatic bit cmd_ok(input logic [7:0] b);
        if (b[7]) return 0;
        if (b[2:0] == 3'd3) return b[6:4] == 3'd0;
        if (b[2:0] == 3'd1 || b[2:0] == 3'd2) return int'(b[6:4]) < NUM_CH;
        return 0;
    endfunction

    function automatic logic [DW-1:0] model_read(input logic [7:0] b);
        int c = int'(b[6:4]);
        case (b[2:0])
            3'd1: return m_off[c];
            3'd2: return m_gain[c];
            default: return m_cfg;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] b, input logic [DW-1:0] d);
        int c = int'(b[6:4]);
        case (b[2:0])
            3'd1: m_off[c] = d;
            3'd2: m_gain[c] = d;
            default: m_cfg = d;
        endcase
    endtask

    task automatic bit_io(input logic b, output logic s);
        sclk = 1'b0;
        sdi = b;
        repeat (HALF) @(negedge clk);
        s = sdo;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic end_frame();
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic check_regs(input string req);
        for (int c = 0; c < NUM_CH; c++) begin
            chk(gain_o[c*DW +: DW] == m_gain[c], req, 64'(gain_o[c*DW +: DW]), 64'(m_gain[c]));
            chk(offset_o[c*DW +: DW] == m_off[c], req, 64'(offset_o[c*DW +: DW]), 64'(m_off[c]));
        end
        chk(cfg_o == m_cfg, req, 64'(cfg_o), 64'(m_cfg));
    endtask

    // one command, plus 24 data bits when the command is valid
    task automatic xfer(input logic [7:0] cmd, input logic [DW-1:0] d, output logic [DW-1:0] got);
        logic s;
        logic quiet = 1'b0;
        got = '0;
        for (int i = 7; i >= 0; i--) begin
            bit_io(cmd[i], s);
            quiet |= s;
        end
        if (cmd_ok(cmd)) begin
            for (int i = DW - 1; i >= 0; i--) begin
                bit_io(d[i], s);
                got[i] = s;
                if (!cmd[3]) quiet |= s;
            end
        end
        end_frame();
        chk(quiet == 1'b0, "R12 sdo quiet outside read data", 64'(quiet), 64'd0);
        if (cmd_ok(cmd)) begin
            if (cmd[3]) begin
                chk(got == model_read(cmd), "R7 read value", 64'(got), 64'(model_read(cmd)));
            end else begin
                model_write(cmd, d);
                check_regs("R6 write result");
            end
        end else begin
            check_regs("R10 ignored command");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] got;
        logic s;
        void'($urandom(32'h5eed_1234));
        for (int c = 0; c < NUM_CH; c++) begin
            m_gain[c] = 24'h800000;
            m_off[c] = '0;
        end
        m_cfg = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        check_regs("R11 reset values");
        chk(sdo_oe == 1'b0, "R2 oe low when deselected", 64'(sdo_oe), 64'd0);
        chk(sdo == 1'b0, "R12 sdo idle after reset", 64'(sdo), 64'd0);

        // R1: a full write frame clocked while deselected
        for (int i = 31; i >= 0; i--) bit_io(((32'h02_123456) >> i) & 1, s);
        end_frame();
        check_regs("R1 deselected clocks ignored");

        sel_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(sdo_oe == 1'b1, "R2 oe high when selected", 64'(sdo_oe), 64'd1);

        // R5 directed gain channel 0 write/read
        xfer(8'h02, 24'hA5C33C, got);
        chk(gain_o[DW-1:0] == 24'hA5C33C, "R5 cmd 0x02 targets gain ch0", 64'(gain_o[DW-1:0]), 64'hA5C33C);
        xfer(8'h0A, '0, got);
        chk(got == 24'hA5C33C, "R4 MSB-first read of 0x0A", 64'(got), 64'hA5C33C);

        // R10 invalid bytes then a valid read
        xfer(8'h07, '0, got);
        xfer(8'h8A, '0, got);
        xfer(8'h13, '0, got);
        xfer(8'h0A, '0, got);
        chk(got == 24'hA5C33C, "R10 framing kept after invalid", 64'(got), 64'hA5C33C);

        // R9 abort in the middle of an offset write
        for (int i = 7; i >= 0; i--) bit_io(((8'h01) >> i) & 1, s);
        for (int i = 0; i < 10; i++) bit_io(1'b1, s);
        end_frame();
        sel_n = 1'b1;
        repeat (6) @(negedge clk);
        check_regs("R9 abort leaves registers");
        sel_n = 1'b0;
        repeat (6) @(negedge clk);
        xfer(8'h09, '0, got);
        chk(got == m_off[0], "R9 fresh frame after abort", 64'(got), 64'(m_off[0]));

        // R3 R8: select held low, random back-to-back traffic
        for (int t = 0; t < 70; t++) begin
            logic [7:0] cmd;
            int k = int'($urandom % 8);
            if (k == 6) begin
                do cmd = 8'($urandom); while (cmd_ok(cmd));
            end else begin
                cmd = {1'b0, 3'($urandom % NUM_CH), 1'($urandom), 3'(($urandom % 3) + 1)};
                if (cmd[2:0] == 3'd3) cmd[6:4] = 3'd0;
            end
            xfer(cmd, 24'($urandom), got);
        end
        for (int c = 0; c < NUM_CH; c++) begin
            xfer({1'b0, 3'(c), 4'hA}, '0, got);
            chk(got == m_gain[c], "R3 three-wire final gain read", 64'(got), 64'(m_gain[c]));
        end
        xfer(8'h0B, '0, got);
        chk(got == m_cfg, "R8 config read after traffic", 64'(got), 64'(m_cfg));

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule